// File: doc/BRIEF.md
# Load/Add Multicycle Processor Core

This block is a small 32-bit processor core that runs two instructions: a word load from memory and a two's complement add that updates the condition flags. It uses one memory read port for both instruction fetch and data reads. The port is byte-addressed and word-wide, and the word it returns is big-endian. The core has 32 general registers. Register zero always reads as zero, so it acts as a zero base for absolute addresses and for loading constants.

Each instruction moves through a fixed sequence of states: fetch, decode, execute, a memory step for loads only, then write-back. A retire port pulses once at write-back and shows the destination register and the value written to it. An encoding the core does not support, or a load address that is not word-aligned, stops the core for good. The matching error output is raised and stays set until reset. The external reset is asynchronous and active low, and the core sees its release through a two-stage synchroniser.

Top module: `ldadd_core`

## Requirements
- R1: While reset is asserted, `mem_addr` is 0 (the program counter is cleared), `cc_flags` is 0, both error outputs are 0 and `rt_valid` is 0.
- R2: Instruction word fields are op = [31:30], rd = [29:25], op3 = [24:19], rs1 = [18:14], imm-select = [13] and the 13-bit constant = [12:0]. When op = 2'b10 and op3 = 6'b010000, the core writes rd with rs1 plus the second operand. The second operand is the sign-extended constant when bit 13 is 1, and the register named by bits [4:0] when bit 13 is 0.
- R3: `cc_flags` bit 3 is N (result bit 31), bit 2 is Z (result is zero), bit 1 is V (signed overflow) and bit 0 is C (carry out of bit 31). The add instruction updates all four at write-back. The load instruction leaves them unchanged.
- R4: When op = 2'b11 and op3 = 6'b000000, the core reads memory at rs1 plus the second operand, formed as in R2, and writes the word to rd. `mem_rdata[31:24]` is the byte at the lowest address.
- R5: Register 0 reads as zero. A write to register 0 is reported on the retire port and then discarded.
- R6: An add takes 4 clock cycles from one retire pulse to the next, and a load takes 5. After each retire pulse the next fetch is at the previous fetch address plus 4. `rt_valid` is high for exactly one cycle per instruction.
- R7: Any other op/op3 pair stops the core in decode, before any register or flag write, and raises `err_illegal`. From then on `halted` is 1 and `mem_rd` and `rt_valid` are 0 until reset.
- R8: A load whose address has either of its two low bits set stops the core without a memory access and raises `err_align`. At most one error output is ever high.
- R9: `mem_rd` is only asserted with a word-aligned `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for a fetch or a data read |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Read word for `mem_addr`, same cycle, big-endian |
| cc_flags | output | 4 | Condition flags {N, Z, V, C} |
| rt_valid | output | 1 | Write-back pulse |
| rt_rd | output | 5 | Destination register of the retiring instruction |
| rt_data | output | 32 | Value written at write-back |
| halted | output | 1 | Core has stopped on an error |
| err_illegal | output | 1 | Unsupported encoding seen |
| err_align | output | 1 | Misaligned load address seen |

## Verification
The bound checker watches properties that hold on every cycle:
- every read is word-aligned;
- flags move only on a write-back cycle;
- a retire pulse lasts one cycle;
- the error outputs are mutually exclusive and stay set;
- a halted core stays silent.

Other behaviour shows up only in the bench's scenarios:
- the arithmetic and flag values;
- sign extension of the constant;
- the zero register;
- big-endian assembly of loaded words;
- per-instruction cycle counts and program counter stepping;
- flags cleared by a later reset.

// File: rtl/ldadd_pkg.sv
package ldadd_pkg;

  localparam logic [1:0] OPC_ARITH = 2'b10;
  localparam logic [1:0] OPC_MEM   = 2'b11;
  localparam logic [5:0] FN_ADDCC  = 6'b010000;
  localparam logic [5:0] FN_LOAD   = 6'b000000;
  localparam int         CONST_W   = 13;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4,
    ST_HALT   = 3'd5
  } state_t;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_LD  = 2'd1,
    K_BAD = 2'd2
  } kind_t;

endpackage

// File: rtl/ldadd_decode.sv
module ldadd_decode
  import ldadd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic [31:0]     instr,
  output kind_t           kind,
  output logic [RW-1:0]   rd,
  output logic [RW-1:0]   rs1,
  output logic [RW-1:0]   rs2,
  output logic            use_imm,
  output logic [XLEN-1:0] imm
);

  logic [1:0] opc;
  logic [5:0] fn;

  assign opc     = instr[31:30];
  assign fn      = instr[24:19];
  assign rd      = instr[25 +: RW];
  assign rs1     = instr[14 +: RW];
  assign rs2     = instr[0 +: RW];
  assign use_imm = instr[13];

  generate
    if (XLEN > CONST_W) begin : g_sext
      assign imm = {{(XLEN-CONST_W){instr[CONST_W-1]}}, instr[CONST_W-1:0]};
    end else begin : g_trunc
      assign imm = instr[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    if (opc == OPC_ARITH && fn == FN_ADDCC) begin
      kind = K_ADD;
    end else if (opc == OPC_MEM && fn == FN_LOAD) begin
      kind = K_LD;
    end else begin
      kind = K_BAD;
    end
  end

endmodule

// File: rtl/ldadd_regfile.sv
module ldadd_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [RW-1:0]   ra1,
  input  logic [RW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/ldadd_alu.sv
module ldadd_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum,
  output logic [3:0]      flg
);

  logic cout;
  logic ovf;

  assign {cout, sum} = {1'b0, a} + {1'b0, b};
  assign ovf = (a[XLEN-1] == b[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
  assign flg = {sum[XLEN-1], (sum == '0), ovf, cout};

endmodule

// File: rtl/ldadd_ctrl.sv
module ldadd_ctrl
  import ldadd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  kind_t  kind,
  input  logic   misaligned,
  output state_t state,
  output logic   ir_en,
  output logic   opnd_en,
  output logic   res_en,
  output logic   mdr_en,
  output logic   wb_en,
  output logic   set_ill,
  output logic   set_aln
);

  state_t nxt;

  always_comb begin
    nxt     = state;
    ir_en   = 1'b0;
    opnd_en = 1'b0;
    res_en  = 1'b0;
    mdr_en  = 1'b0;
    wb_en   = 1'b0;
    set_ill = 1'b0;
    set_aln = 1'b0;
    case (state)
      ST_FETCH: begin
        ir_en = 1'b1;
        nxt   = ST_DECODE;
      end
      ST_DECODE: begin
        if (kind == K_BAD) begin
          set_ill = 1'b1;
          nxt     = ST_HALT;
        end else begin
          opnd_en = 1'b1;
          nxt     = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (kind == K_LD && misaligned) begin
          set_aln = 1'b1;
          nxt     = ST_HALT;
        end else begin
          res_en = 1'b1;
          nxt    = (kind == K_LD) ? ST_MEM : ST_WB;
        end
      end
      ST_MEM: begin
        mdr_en = 1'b1;
        nxt    = ST_WB;
      end
      ST_WB: begin
        wb_en = 1'b1;
        nxt   = ST_FETCH;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
    end else begin
      state <= nxt;
    end
  end

endmodule

// File: rtl/ldadd_core.sv
module ldadd_core
  import ldadd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [3:0]      cc_flags,
  output logic            rt_valid,
  output logic [RW-1:0]   rt_rd,
  output logic [XLEN-1:0] rt_data,
  output logic            halted,
  output logic            err_illegal,
  output logic            err_align
);

  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [1:0]      rst_sync;
  logic            rst_core_n;
  state_t          state;
  logic            ir_en, opnd_en, res_en, mdr_en, wb_en, set_ill, set_aln;
  logic [31:0]     ir;
  logic [XLEN-1:0] pc, opa, opb, res, mdr;
  kind_t           kind;
  logic [RW-1:0]   f_rd, f_rs1, f_rs2;
  logic            use_imm;
  logic [XLEN-1:0] imm, rf_a, rf_b, alu_sum, wb_data;
  logic [3:0]      alu_flg;
  logic            flag_en;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  ldadd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .kind       (kind),
    .misaligned (alu_sum[1:0] != 2'b00),
    .state      (state),
    .ir_en      (ir_en),
    .opnd_en    (opnd_en),
    .res_en     (res_en),
    .mdr_en     (mdr_en),
    .wb_en      (wb_en),
    .set_ill    (set_ill),
    .set_aln    (set_aln)
  );

  ldadd_decode #(.XLEN(XLEN), .RW(RW)) u_dec (
    .instr   (ir),
    .kind    (kind),
    .rd      (f_rd),
    .rs1     (f_rs1),
    .rs2     (f_rs2),
    .use_imm (use_imm),
    .imm     (imm)
  );

  ldadd_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .we  (wb_en),
    .wa  (f_rd),
    .wd  (wb_data),
    .ra1 (f_rs1),
    .ra2 (f_rs2),
    .rd1 (rf_a),
    .rd2 (rf_b)
  );

  ldadd_alu #(.XLEN(XLEN)) u_alu (
    .a   (opa),
    .b   (opb),
    .sum (alu_sum),
    .flg (alu_flg)
  );

  // architectural state with reset
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc          <= '0;
      ir          <= '0;
      cc_flags    <= '0;
      err_illegal <= 1'b0;
      err_align   <= 1'b0;
    end else begin
      if (wb_en) begin
        pc <= pc + PC_STEP;
      end
      if (ir_en) begin
        ir <= mem_rdata[31:0];
      end
      if (flag_en) begin
        cc_flags <= alu_flg;
      end
      if (set_ill) begin
        err_illegal <= 1'b1;
      end
      if (set_aln) begin
        err_align <= 1'b1;
      end
    end
  end

  // datapath staging registers, no reset
  always_ff @(posedge clk) begin
    if (opnd_en) begin
      opa <= rf_a;
      opb <= use_imm ? imm : rf_b;
    end
    if (res_en) begin
      res <= alu_sum;
    end
    if (mdr_en) begin
      mdr <= mem_rdata;
    end
  end

  assign flag_en  = wb_en && (kind == K_ADD);
  assign wb_data  = (kind == K_LD) ? mdr : res;
  assign mem_addr = (state == ST_MEM) ? res : pc;
  assign mem_rd   = (state == ST_FETCH) || (state == ST_MEM);
  assign halted   = (state == ST_HALT);
  assign rt_valid = wb_en;
  assign rt_rd    = f_rd;
  assign rt_data  = wb_data;

endmodule

// File: rtl/ldadd_core_chk.sv
module ldadd_core_chk #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_rd,
  input logic [3:0]      cc_flags,
  input logic            rt_valid,
  input logic            halted,
  input logic            err_illegal,
  input logic            err_align
);

  // R9: every read is word-aligned
  a_r9_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[1:0] == 2'b00));

  // R3: flags only move on a write-back cycle
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_valid |=> $stable(cc_flags));

  // R6: one retire pulse per instruction
  a_r6_retire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |=> !rt_valid);

  // R8: at most one error flag
  a_r8_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_illegal, err_align}));

  // R7: errors stay set once raised
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_illegal || err_align) |=> $stable({err_illegal, err_align}));

  // R7: a halted core issues no reads and retires nothing
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !rt_valid));

endmodule

bind ldadd_core ldadd_core_chk #(.XLEN(XLEN), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_addr    (mem_addr),
  .mem_rd      (mem_rd),
  .cc_flags    (cc_flags),
  .rt_valid    (rt_valid),
  .halted      (halted),
  .err_illegal (err_illegal),
  .err_align   (err_align)
);

// File: tb/sim_ldadd_core.sv
`timescale 1ns/1ps
module sim_ldadd_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic [31:0] mem_rdata;
  logic [3:0]  cc_flags;
  logic        rt_valid;
  logic [4:0]  rt_rd;
  logic [31:0] rt_data;
  logic        halted, err_illegal, err_align;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mem [512];

  always #10 clk = ~clk;

  ldadd_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .cc_flags(cc_flags), .rt_valid(rt_valid),
    .rt_rd(rt_rd), .rt_data(rt_data), .halted(halted),
    .err_illegal(err_illegal), .err_align(err_align)
  );

  // big-endian read model: lowest byte address lands in bits 31:24
  always_comb begin
    logic [8:0] b;
    b = mem_addr[8:0];
    mem_rdata = {mem[b], mem[b + 9'd1], mem[b + 9'd2], mem[b + 9'd3]};
  end

  function automatic logic [31:0] enc(input logic [1:0] op, input logic [4:0] rd,
                                      input logic [5:0] fn, input logic [4:0] rs1,
                                      input logic i, input logic [12:0] lo);
    return {op, rd, fn, rs1, i, lo};
  endfunction

  function automatic logic [72:0] mk(input logic [31:0] ins, input logic [4:0] rd,
                                     input logic [31:0] val, input logic [3:0] fl);
    return {ins, rd, val, fl};
  endfunction

  localparam logic [1:0] A = 2'b10;
  localparam logic [1:0] L = 2'b11;
  localparam logic [5:0] FA = 6'b010000;
  localparam logic [5:0] FL = 6'b000000;
  localparam int NV = 12;

  // {instruction, expected rd, expected write value, flags after write-back}
  localparam logic [72:0] VEC [NV] = '{
    mk(enc(A, 5'd1,  FA, 5'd0,  1'b1, 13'd5),      5'd1,  32'h0000_0005, 4'b0000),
    mk(enc(A, 5'd2,  FA, 5'd0,  1'b1, 13'h1FFF),   5'd2,  32'hFFFF_FFFF, 4'b1000),
    mk(enc(A, 5'd3,  FA, 5'd1,  1'b0, 13'd2),      5'd3,  32'h0000_0004, 4'b0001),
    mk(enc(A, 5'd4,  FA, 5'd2,  1'b1, 13'd1),      5'd4,  32'h0000_0000, 4'b0101),
    mk(enc(L, 5'd5,  FL, 5'd0,  1'b1, 13'h100),    5'd5,  32'h1234_5678, 4'b0101),
    mk(enc(A, 5'd0,  FA, 5'd1,  1'b0, 13'd1),      5'd0,  32'h0000_000A, 4'b0000),
    mk(enc(A, 5'd6,  FA, 5'd0,  1'b0, 13'd0),      5'd6,  32'h0000_0000, 4'b0100),
    mk(enc(A, 5'd8,  FA, 5'd0,  1'b1, 13'h104),    5'd8,  32'h0000_0104, 4'b0000),
    mk(enc(L, 5'd9,  FL, 5'd8,  1'b0, 13'd0),      5'd9,  32'hAABB_CCDD, 4'b0000),
    mk(enc(L, 5'd10, FL, 5'd0,  1'b1, 13'h108),    5'd10, 32'h7FFF_FFFF, 4'b0000),
    mk(enc(A, 5'd11, FA, 5'd10, 1'b0, 13'd1),      5'd11, 32'h8000_0004, 4'b1010),
    mk(enc(L, 5'd12, FL, 5'd8,  1'b1, 13'h1FFC),   5'd12, 32'h1234_5678, 4'b1010)
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_word(input int addr, input logic [31:0] w);
    mem[addr]     = w[31:24];
    mem[addr + 1] = w[23:16];
    mem[addr + 2] = w[15:8];
    mem[addr + 3] = w[7:0];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // watches for a retire pulse over a few cycles after the core should stop
  task automatic expect_halt(input string tag, input bit want_ill, input bit want_aln);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (rt_valid) seen = 1'b1;
    end
    chk(!seen, tag, 32'(seen), 32'd0);
    chk(err_illegal == want_ill && err_align == want_aln, tag,
        {30'd0, err_illegal, err_align}, {30'd0, want_ill, want_aln});
    chk(halted && !mem_rd, tag, {30'd0, halted, mem_rd}, 32'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [31:0] ins;
    string tg;
    for (int a = 0; a < 512; a++) mem[a] = 8'h00;
    for (int v = 0; v < NV; v++) put_word(4 * v, VEC[v][72:41]);
    // misaligned load after the table: address r1 + r0 = 5
    put_word(4 * NV, enc(L, 5'd13, FL, 5'd1, 1'b0, 13'd0));
    put_word(32'h100, 32'h1234_5678);
    put_word(32'h104, 32'hAABB_CCDD);
    put_word(32'h108, 32'h7FFF_FFFF);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(mem_addr == 32'd0, "R1 pc", mem_addr, 32'd0);
    chk(cc_flags == 4'd0 && !err_illegal && !err_align && !rt_valid, "R1 outputs",
        {24'd0, cc_flags, err_illegal, err_align, rt_valid, 1'b0}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      ins = VEC[i][72:41];
      if (i == 0) begin
        n = 0;
        while (!rt_valid) @(negedge clk);
      end else begin
        n = 1;
        do begin
          @(negedge clk);
          n++;
        end while (!rt_valid);
        chk(n == (ins[30] ? 5 : 4), "R6 cycles", n, ins[30] ? 5 : 4);
      end
      tg = (i == 5 || i == 6) ? "R5" : (ins[30] ? "R4" : "R2");
      chk(rt_rd == VEC[i][40:36], tg, {27'd0, rt_rd}, {27'd0, VEC[i][40:36]});
      chk(rt_data == VEC[i][35:4], tg, rt_data, VEC[i][35:4]);
      @(negedge clk);
      chk(cc_flags == VEC[i][3:0], "R3 flags", {28'd0, cc_flags}, {28'd0, VEC[i][3:0]});
      chk(mem_addr == 32'(4 * (i + 1)) && mem_rd, "R6 next fetch", mem_addr, 32'(4 * (i + 1)));
    end

    // R8: misaligned load stops the core
    expect_halt("R8", 1'b0, 1'b1);

    // R1: a second reset clears flags that were 1010
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cc_flags == 4'd0 && !err_align && mem_addr == 32'd0, "R1 re-reset",
        {28'd0, cc_flags}, 32'd0);

    // R7: arithmetic opcode with an unsupported function field
    put_word(0, enc(A, 5'd1, 6'b000001, 5'd0, 1'b1, 13'd5));
    rst_n = 1'b1;
    expect_halt("R7 bad fn", 1'b1, 1'b0);

    // R7: op = 00 is not supported
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    put_word(0, 32'h0000_0000);
    rst_n = 1'b1;
    expect_halt("R7 bad op", 1'b1, 1'b0);

    finish_run();
  end

endmodule